// File: doc/BRIEF.md
# Nested-Count Burst DMA Channel

This block is one DMA channel that copies 32-bit words from an incrementing memory address to one fixed address, typically the data register of a peripheral transmit FIFO. Each trigger moves one burst. The inner count sets the number of words in a burst. The outer count sets the number of bursts in a job. A trigger is either a pulse on the hardware request input, such as a FIFO-empty event steered to the channel, or a software start written through the register port. With a software start, the FIFO can be primed with a first burst before it ever reports empty.

Software programs the source pointer, the destination, and both counts. It then sets the enable bit, with or without a start. The engine performs each word as a read on the master read port followed by a write on the master write port. Each uses a valid/ready handshake. When the last burst of the job finishes, a sticky done flag drives the interrupt and the enable bit clears itself.

The engine is a five-state machine:
- ST_IDLE: waits for an enabled, pending trigger. It takes the trigger, reloads the inner counter and moves to ST_READ.
- ST_READ: holds a read request. On ready it captures the data and moves to ST_WRITE.
- ST_WRITE: holds the write request. On ready it advances the source pointer. It returns to ST_READ while words remain in the burst, and otherwise moves to ST_BURST_END.
- ST_BURST_END: decrements the remaining burst count. It moves to ST_FINISH when that was the last burst, and otherwise returns to ST_IDLE.
- ST_FINISH: sets the done flag, clears enable and returns to ST_IDLE.

Top module: `bdma_chan`

## Requirements
- R1: A burst performs exactly inner-count word transfers. Each transfer reads the current source pointer and then writes that same word to the destination address. The destination address never changes. The source pointer advances by 4 after every write handshake. Reading register word address 1 returns the current source pointer.
- R2: The remaining-burst count decrements once per completed burst. The job ends after the burst that takes it from 1 to 0. Reading word address 4 returns the remaining count, and writing word address 4 loads it.
- R3: A write to the control register (word address 0) with bit 0 (enable) and bit 1 (start) both set issues one burst with no hardware request. Bit 1 always reads back as 0.
- R4: A one-cycle pulse on `hw_req` while the channel is enabled issues one burst.
- R5: Triggers that arrive while a burst is running are counted. Up to 2^PEND_W-1 of them are held, and each is serviced as its own burst after the current one. None is lost within that limit.
- R6: While enable is 0, `hw_req` pulses have no effect and no trigger is held. Setting enable later without a start issues no burst. Clearing enable during a burst lets that burst finish.
- R7: After the last burst, status bit 0 (word address 5) and `irq` go high and stay high until status bit 0 is written with 1. Control bit 0 is cleared by hardware at the same time.
- R8: Writing 0 to the inner count (word address 3) or to the outer count (word address 4) stores 1, and the register reads back 1.
- R9: At most one of `rd_valid` and `wr_valid` is high at any time. A request holds its valid, address and data stable until ready is seen.
- R10: After reset, `irq`, `rd_valid` and `wr_valid` are low, and the control and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| hw_req | input | 1 | Hardware burst request, one pulse per burst |
| rd_valid | output | 1 | Master read request valid |
| rd_addr | output | ADDR_W | Master read address |
| rd_ready | input | 1 | Read accepted; rd_data valid in this cycle |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Master write request valid |
| wr_addr | output | ADDR_W | Master write address |
| wr_data | output | 32 | Master write data |
| wr_ready | input | 1 | Write accepted |
| irq | output | 1 | Job-complete interrupt (sticky) |

## Verification
The bench fires hardware requests in the cycles right after a software start, while the first burst is still running. A channel that kept a single flag, or none, would run fewer bursts and never raise the interrupt. Zero counts are written and then run. A design without the substitution would either run a near-endless burst or read back 0. Pulses sent while disabled are followed by a plain enable, which would start a spurious burst in a design that buffered them. Slow ready patterns on both master ports expose data captured in the wrong cycle and addresses that move before the handshake completes.

// File: rtl/bdma_pkg.sv
`timescale 1ns/1ps
package bdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_BURST_END,
        ST_FINISH
    } eng_state_t;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_SRC   = 3'd1;
    localparam logic [2:0] RA_DST   = 3'd2;
    localparam logic [2:0] RA_INNER = 3'd3;
    localparam logic [2:0] RA_OUTER = 3'd4;
    localparam logic [2:0] RA_STAT  = 3'd5;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int STAT_DONE_BIT = 0;

endpackage

// File: rtl/bdma_regs.sv
`timescale 1ns/1ps
module bdma_regs
    import bdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          fin_i,
    input  logic [AW-1:0] cur_src_i,
    input  logic [CW-1:0] cur_outer_i,
    output logic          en_o,
    output logic          go_o,
    output logic [AW-1:0] dst_o,
    output logic [CW-1:0] inner_o,
    output logic          done_o,
    output logic          ld_src_o,
    output logic          ld_outer_o
);

    logic          en_q;
    logic          done_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] inner_q;
    logic [CW-1:0] wr_cnt;

    logic wr_ctrl, wr_dst, wr_inner, wr_stat;

    always_comb begin
        wr_ctrl    = reg_we && (reg_addr == RA_CTRL);
        wr_dst     = reg_we && (reg_addr == RA_DST);
        wr_inner   = reg_we && (reg_addr == RA_INNER);
        wr_stat    = reg_we && (reg_addr == RA_STAT);
        ld_src_o   = reg_we && (reg_addr == RA_SRC);
        ld_outer_o = reg_we && (reg_addr == RA_OUTER);
        go_o       = wr_ctrl && reg_wdata[CTRL_GO_BIT] && reg_wdata[CTRL_EN_BIT];
        wr_cnt     = (reg_wdata[CW-1:0] == '0) ? CW'(1) : reg_wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            done_q  <= 1'b0;
            dst_q   <= '0;
            inner_q <= CW'(1);
        end else begin
            if (fin_i) begin
                en_q <= 1'b0;
            end else if (wr_ctrl) begin
                en_q <= reg_wdata[CTRL_EN_BIT];
            end

            if (fin_i) begin
                done_q <= 1'b1;
            end else if (wr_stat && reg_wdata[STAT_DONE_BIT]) begin
                done_q <= 1'b0;
            end

            if (wr_dst) begin
                dst_q <= AW'(reg_wdata);
            end
            if (wr_inner) begin
                inner_q <= wr_cnt;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:  reg_rdata[CTRL_EN_BIT]   = en_q;
            RA_SRC:   reg_rdata                = 32'(cur_src_i);
            RA_DST:   reg_rdata                = 32'(dst_q);
            RA_INNER: reg_rdata                = 32'(inner_q);
            RA_OUTER: reg_rdata                = 32'(cur_outer_i);
            RA_STAT:  reg_rdata[STAT_DONE_BIT] = done_q;
            default:  reg_rdata                = '0;
        endcase
    end

    assign en_o    = en_q;
    assign dst_o   = dst_q;
    assign inner_o = inner_q;
    assign done_o  = done_q;

endmodule

// File: rtl/bdma_req_q.sv
`timescale 1ns/1ps
module bdma_req_q #(
    parameter int PW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hw_req_i,
    input  logic go_i,
    input  logic take_i,
    output logic pend_o
);

    localparam int SW = PW + 2;
    localparam logic [SW-1:0] CNT_MAX = SW'({PW{1'b1}});

    logic [PW-1:0] cnt_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(cnt_q) + SW'(en_i & hw_req_i) + SW'(go_i) - SW'(take_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i && !go_i) begin
            cnt_q <= '0;
        end else if (sum > CNT_MAX) begin
            cnt_q <= {PW{1'b1}};
        end else begin
            cnt_q <= sum[PW-1:0];
        end
    end

    assign pend_o = |cnt_q;

endmodule

// File: rtl/bdma_engine.sv
`timescale 1ns/1ps
module bdma_engine
    import bdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          pend_i,
    input  logic [CW-1:0] inner_i,
    input  logic [AW-1:0] dst_i,
    input  logic          ld_src_i,
    input  logic          ld_outer_i,
    input  logic [31:0]   ld_val_i,
    output logic          take_o,
    output logic          fin_o,
    output logic [AW-1:0] cur_src_o,
    output logic [CW-1:0] cur_outer_o,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready
);

    localparam int            STEP   = DW / 8;
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    eng_state_t    st_q, st_d;
    logic [AW-1:0] src_q;
    logic [CW-1:0] inner_left_q;
    logic [CW-1:0] outer_left_q;
    logic [DW-1:0] data_q;
    logic          start_ok;
    logic          last_word;
    logic          last_burst;
    logic [CW-1:0] ld_cnt;

    always_comb begin
        start_ok   = en_i && pend_i;
        last_word  = (inner_left_q <= CW'(1));
        last_burst = (outer_left_q <= CW'(1));
        ld_cnt     = (ld_val_i[CW-1:0] == '0) ? CW'(1) : ld_val_i[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (start_ok) st_d = ST_READ;
            ST_READ:      if (rd_ready) st_d = ST_WRITE;
            ST_WRITE:     if (wr_ready) st_d = last_word ? ST_BURST_END : ST_READ;
            ST_BURST_END: st_d = last_burst ? ST_FINISH : ST_IDLE;
            ST_FINISH:    st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_o   = 1'b0;
        fin_o    = 1'b0;
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        unique case (st_q)
            ST_IDLE:      take_o   = start_ok;
            ST_READ:      rd_valid = 1'b1;
            ST_WRITE:     wr_valid = 1'b1;
            ST_BURST_END: ;
            ST_FINISH:    fin_o    = 1'b1;
            default:      ;
        endcase
        rd_addr = src_q;
        wr_addr = dst_i;
        wr_data = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q        <= '0;
            inner_left_q <= CW'(1);
            outer_left_q <= '0;
            data_q       <= '0;
        end else begin
            if (ld_src_i) begin
                src_q <= AW'(ld_val_i);
            end else if (st_q == ST_WRITE && wr_ready) begin
                src_q <= src_q + STEP_V;
            end

            if (st_q == ST_IDLE && start_ok) begin
                inner_left_q <= inner_i;
            end else if (st_q == ST_WRITE && wr_ready && !last_word) begin
                inner_left_q <= inner_left_q - CW'(1);
            end

            if (ld_outer_i) begin
                outer_left_q <= ld_cnt;
            end else if (st_q == ST_BURST_END && outer_left_q != '0) begin
                outer_left_q <= outer_left_q - CW'(1);
            end

            if (st_q == ST_READ && rd_ready) begin
                data_q <= rd_data;
            end
        end
    end

    assign cur_src_o   = src_q;
    assign cur_outer_o = outer_left_q;

endmodule

// File: rtl/bdma_chan.sv
`timescale 1ns/1ps
module bdma_chan #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hw_req,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              irq
);

    localparam int DATA_W = 32;

    logic              en_w, go_w, done_w, fin_w, take_w, pend_w;
    logic              ld_src_w, ld_outer_w;
    logic [ADDR_W-1:0] dst_w, cur_src_w;
    logic [CNT_W-1:0]  inner_w, cur_outer_w;

    bdma_regs #(.AW(ADDR_W), .CW(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fin_i      (fin_w),
        .cur_src_i  (cur_src_w),
        .cur_outer_i(cur_outer_w),
        .en_o       (en_w),
        .go_o       (go_w),
        .dst_o      (dst_w),
        .inner_o    (inner_w),
        .done_o     (done_w),
        .ld_src_o   (ld_src_w),
        .ld_outer_o (ld_outer_w)
    );

    bdma_req_q #(.PW(PEND_W)) reqq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_w),
        .hw_req_i(hw_req),
        .go_i    (go_w),
        .take_i  (take_w),
        .pend_o  (pend_w)
    );

    bdma_engine #(.AW(ADDR_W), .CW(CNT_W), .DW(DATA_W)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_w),
        .pend_i     (pend_w),
        .inner_i    (inner_w),
        .dst_i      (dst_w),
        .ld_src_i   (ld_src_w),
        .ld_outer_i (ld_outer_w),
        .ld_val_i   (reg_wdata),
        .take_o     (take_w),
        .fin_o      (fin_w),
        .cur_src_o  (cur_src_w),
        .cur_outer_o(cur_outer_w),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready)
    );

    assign irq = done_w;

endmodule

// File: rtl/bdma_chk.sv
`timescale 1ns/1ps
module bdma_chk
    import bdma_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ready,
    input logic [31:0]   rd_data,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic          wr_ready,
    input logic          irq
);

    logic irq_clr;
    assign irq_clr = reg_we && (reg_addr == RA_STAT) && reg_wdata[STAT_DONE_BIT];

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid)); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9

    AST_WR_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> wr_valid && (wr_data == $past(rd_data))); // R1

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq); // R7

endmodule

bind bdma_chan bdma_chk #(.AW(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .irq      (irq)
);

// File: tb/bdma_chan_tb.sv
`timescale 1ns/1ps
module bdma_chan_tb_top;

    localparam logic [31:0] KEY = 32'h5A5A_0000;
    localparam logic [31:0] DST = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        hw_req = 1'b0;
    logic        rd_valid, wr_valid, irq;
    logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
    logic        rd_ready = 1'b0;
    logic        wr_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int nw = 0;
    int cyc = 0;
    bit slow = 1'b0;
    bit ended = 1'b0;
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];

    always #2 clk = ~clk;

    assign rd_data = rd_addr ^ KEY;

    bdma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .irq(irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        rd_ready = rd_valid && (!slow || (cyc % 3 == 0));
        wr_ready = wr_valid && (!slow || (cyc % 4 == 1));
        if (wr_valid && wr_ready && nw < 64) begin
            log_addr[nw] = wr_addr;
            log_data[nw] = wr_data;
            nw = nw + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
    endtask

    task automatic check_words(input int first, input int cnt, input logic [31:0] src0, input string tag);
        for (int i = 0; i < cnt; i++) begin
            check(log_addr[first+i] == DST, tag, log_addr[first+i], DST);
            check(log_data[first+i] == ((src0 + 32'(4*i)) ^ KEY), tag,
                  log_data[first+i], (src0 + 32'(4*i)) ^ KEY);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(irq == 1'b0, "R10 irq", {31'd0, irq}, 0);
        check(rd_valid == 1'b0 && wr_valid == 1'b0, "R10 valids", {30'd0, rd_valid, wr_valid}, 0);
        reg_rd(3'd0, v); check(v == 0, "R10 ctrl", v, 0);
        reg_rd(3'd5, v); check(v == 0, "R10 stat", v, 0);
    endtask

    task automatic t_soft_then_hw();
        logic [31:0] v;
        int n0;
        reg_wr(3'd1, 32'h100);
        reg_wr(3'd2, DST);
        reg_wr(3'd3, 32'd4);
        reg_wr(3'd4, 32'd3);
        n0 = nw;
        reg_wr(3'd0, 32'h3);
        idle(40);
        check(nw - n0 == 4, "R3 soft start burst length", nw - n0, 4);
        check_words(n0, 4, 32'h100, "R1 first burst");
        reg_rd(3'd4, v); check(v == 2, "R2 outer after burst 1", v, 2);
        reg_rd(3'd1, v); check(v == 32'h110, "R1 source pointer", v, 32'h110);
        reg_rd(3'd3, v); check(v == 4, "R1 inner kept", v, 4);
        check(irq == 1'b0, "R7 no irq mid job", {31'd0, irq}, 0);
        n0 = nw;
        pulse_req();
        idle(40);
        check(nw - n0 == 4, "R4 hw burst length", nw - n0, 4);
        check_words(n0, 4, 32'h110, "R4 hw burst data");
        reg_rd(3'd4, v); check(v == 1, "R2 outer after burst 2", v, 1);
        pulse_req();
        idle(40);
        check(irq == 1'b1, "R7 irq at end", {31'd0, irq}, 1);
        reg_rd(3'd5, v); check(v == 1, "R7 status done", v, 1);
        reg_rd(3'd0, v); check(v == 0, "R7 enable self clear", v, 0);
        reg_rd(3'd4, v); check(v == 0, "R2 outer exhausted", v, 0);
        n0 = nw;
        pulse_req();
        idle(30);
        check(nw == n0, "R6 no burst after job end", nw - n0, 0);
        idle(5);
        check(irq == 1'b1, "R7 irq sticky", {31'd0, irq}, 1);
        reg_wr(3'd5, 32'h1);
        check(irq == 1'b0, "R7 w1c clear", {31'd0, irq}, 0);
    endtask

    task automatic t_queue();
        int n0;
        reg_wr(3'd1, 32'h200);
        reg_wr(3'd3, 32'd2);
        reg_wr(3'd4, 32'd4);
        n0 = nw;
        reg_wr(3'd0, 32'h3);
        pulse_req();
        pulse_req();
        pulse_req();
        idle(60);
        check(nw - n0 == 8, "R5 queued bursts", nw - n0, 8);
        check_words(n0, 8, 32'h200, "R5 queued data");
        check(irq == 1'b1, "R5 job done", {31'd0, irq}, 1);
        reg_wr(3'd5, 32'h1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int n0;
        reg_wr(3'd3, 32'd0);
        reg_wr(3'd4, 32'd0);
        reg_rd(3'd3, v); check(v == 1, "R8 inner zero", v, 1);
        reg_rd(3'd4, v); check(v == 1, "R8 outer zero", v, 1);
        reg_wr(3'd1, 32'h300);
        n0 = nw;
        reg_wr(3'd0, 32'h3);
        idle(30);
        check(nw - n0 == 1, "R8 single word job", nw - n0, 1);
        check_words(n0, 1, 32'h300, "R8 data");
        check(irq == 1'b1, "R8 job done", {31'd0, irq}, 1);
        reg_wr(3'd5, 32'h1);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int n0;
        reg_wr(3'd1, 32'h400);
        reg_wr(3'd3, 32'd2);
        reg_wr(3'd4, 32'd5);
        reg_wr(3'd0, 32'h0);
        n0 = nw;
        pulse_req();
        idle(20);
        check(nw == n0, "R6 ignored while disabled", nw - n0, 0);
        reg_wr(3'd0, 32'h1);
        idle(20);
        check(nw == n0, "R6 nothing held", nw - n0, 0);
        pulse_req();
        idle(30);
        check(nw - n0 == 2, "R4 enabled request", nw - n0, 2);
        check_words(n0, 2, 32'h400, "R4 data");
        reg_wr(3'd0, 32'h0);
        n0 = nw;
        pulse_req();
        idle(20);
        check(nw == n0, "R6 disabled again", nw - n0, 0);
        reg_rd(3'd4, v); check(v == 4, "R6 outer untouched", v, 4);
    endtask

    task automatic t_stall();
        int n0;
        slow = 1'b1;
        reg_wr(3'd1, 32'h500);
        reg_wr(3'd3, 32'd3);
        reg_wr(3'd4, 32'd1);
        n0 = nw;
        reg_wr(3'd0, 32'h3);
        idle(100);
        check(nw - n0 == 3, "R9 stalled burst length", nw - n0, 3);
        check_words(n0, 3, 32'h500, "R9 stalled data");
        check(irq == 1'b1, "R9 stalled job done", {31'd0, irq}, 1);
        slow = 1'b0;
        reg_wr(3'd5, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_soft_then_hw();
        t_queue();
        t_zero();
        t_disabled();
        t_stall();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule